// File: doc/BRIEF.md
# Four-Lane Receive Character Normalizer

This block sits between the per-lane 8b/10b decoders and the receive elasticity FIFO of a four-lane link. Each clock it takes one column: per lane a decoded byte, a control flag and a code-violation flag. It turns every lane into a 10-bit internal word: bit 9 is the error bit, bit 8 the control bit, bits 7:0 the byte. Plain data passes unchanged. The recognised control characters keep their byte with the control bit set. Idle characters are either kept or replaced by a configurable internal idle value. Violations and unknown control characters become an error word.

Idle columns get extra handling so that the FIFO can add or drop them freely. When all four lanes carry idle, the first such column after traffic is stored as mapped. Every further all-idle column reproduces that stored pattern exactly, until a column with any non-idle lane arrives. A shared XAUI enable overrides two settings: it forces idle translation on and fixes the error value.

Top module: `nrm_column_normalizer`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is low, `out_word` holds its value and that column has no effect.
- R2: Lane l input is `in_data[8l+7:8l]`, and lane l output is `out_word[10l+9:10l]`. A lane with control flag 0 and no violation gives `{1'b0, 1'b0, byte}` for any byte 00h..FFh.
- R3: A control lane carrying FBh, FDh, 3Ch, 5Ch, 9Ch, DCh, FCh or F7h gives `{1'b0, 1'b1, byte}`.
- R4: A control lane carrying FEh (K30.7) gives 3FEh, with both the error and control bits set.
- R5: A lane with its violation flag set, or a control lane with a byte outside the idle set, the R3 set and FEh, gives `{1'b1, cfg_error}` when `cfg_xaui` is 0. A violation flag on an idle byte also makes that lane an error lane and not an idle lane.
- R6: With `cfg_xaui` set, such error lanes give 3FEh whatever `cfg_error` holds.
- R7: The idle set is control bytes BCh, 7Ch and 1Ch. With `cfg_translate` and `cfg_xaui` both 0, an idle lane gives `{1'b0, 1'b1, byte}`.
- R8: With `cfg_translate` or `cfg_xaui` set, an idle lane gives `{1'b0, cfg_idle}`.
- R9: The first valid all-idle column after a valid column with any non-idle lane is output as mapped by R7/R8. Each later valid all-idle column outputs that same word again, until a non-idle column arrives, even if the idle bytes or the configuration change.
- R10: After reset the column tracking state is "last column non-idle", so the first all-idle column is captured. During reset `out_valid` and `out_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Column present on the inputs |
| in_data | input | 8*LANES | Decoded byte per lane |
| in_ctrl | input | LANES | Control-character flag per lane |
| in_viol | input | LANES | Code-violation flag per lane |
| cfg_translate | input | 1 | Replace idle characters by the internal idle value |
| cfg_xaui | input | 1 | Force translation and the fixed error value |
| cfg_idle | input | 9 | Internal idle value {control, byte} |
| cfg_error | input | 9 | Error value {control, byte} |
| out_valid | output | 1 | Output column valid |
| out_word | output | 10*LANES | Normalized word per lane {error, control, byte} |

## Verification
The bound checker checks on every clock the one-cycle valid latency and the output hold when no column is valid. It also checks data passthrough, the K30.7 word, the error word with and without the XAUI override, and idle mapping in mixed columns with and without translation. For runs of all-idle columns it checks that the output stays unchanged. What only the bench scenarios can show is whether the capture happens at the right column: the first all-idle column after reset, after a non-idle column, and after a gap in valid columns. The scenarios also show that a repeated pattern survives a change of idle bytes or of configuration, and that unknown control bytes are rejected.

// File: rtl/nrm_pkg.sv
// Package nrm_pkg
// Shared widths, character byte values and classification helpers for the
// column normalizer. Assumes characters arrive already decoded to a byte
// plus a control flag.
package nrm_pkg;
    localparam int BYTE_W = 8;
    localparam int CFG_W  = BYTE_W + 1;      // {control, byte}
    localparam int WORD_W = BYTE_W + 2;      // {error, control, byte}

    localparam logic [BYTE_W-1:0] IDLE_SYNC  = 8'hBC;
    localparam logic [BYTE_W-1:0] IDLE_ALIGN = 8'h7C;
    localparam logic [BYTE_W-1:0] IDLE_SKIP  = 8'h1C;
    localparam logic [BYTE_W-1:0] ERR_CHAR   = 8'hFE;
    localparam logic [CFG_W-1:0]  ERR_FORCED = 9'h1FE;

    // True for the three idle control bytes.
    function automatic logic is_idle_byte(input logic [BYTE_W-1:0] b);
        return (b == IDLE_SYNC) || (b == IDLE_ALIGN) || (b == IDLE_SKIP);
    endfunction

    // True for the non-idle control bytes that pass through unchanged.
    function automatic logic is_kept_ctrl(input logic [BYTE_W-1:0] b);
        case (b)
            8'hFB, 8'hFD, 8'h3C, 8'h5C,
            8'h9C, 8'hDC, 8'hFC, 8'hF7: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    // Assemble an internal word.
    function automatic logic [WORD_W-1:0] make_word(input logic err,
                                                    input logic ctl,
                                                    input logic [BYTE_W-1:0] b);
        return {err, ctl, b};
    endfunction
endpackage

// File: rtl/nrm_cfg_resolve.sv
// Module nrm_cfg_resolve
// Resolves the register inputs into the effective translate enable and
// the effective error value. The XAUI enable overrides both settings.
// Purely combinational; assumes the configuration is quasi-static.
module nrm_cfg_resolve
    import nrm_pkg::*;
(
    input  logic             cfg_translate_i,
    input  logic             cfg_xaui_i,
    input  logic [CFG_W-1:0] cfg_error_i,
    output logic             trans_eff_o,
    output logic [CFG_W-1:0] err_val_o
);
    // Apply the override of the XAUI enable.
    always_comb begin
        trans_eff_o = cfg_translate_i | cfg_xaui_i;
        err_val_o   = cfg_xaui_i ? ERR_FORCED : cfg_error_i;
    end
endmodule

// File: rtl/nrm_lane_map.sv
// Module nrm_lane_map
// Maps one decoded lane character to its 10-bit internal word. It also
// reports whether the lane carries a clean idle character. Combinational.
// Assumes a violation flag overrides whatever byte the decoder produced.
module nrm_lane_map
    import nrm_pkg::*;
(
    input  logic [BYTE_W-1:0] data_i,
    input  logic              ctrl_i,
    input  logic              viol_i,
    input  logic              trans_eff_i,
    input  logic [CFG_W-1:0]  idle_val_i,
    input  logic [CFG_W-1:0]  err_val_i,
    output logic [WORD_W-1:0] word_o,
    output logic              idle_o
);
    // Classify the lane as idle only for a clean idle control character.
    always_comb begin
        idle_o = ctrl_i && !viol_i && is_idle_byte(data_i);
    end

    // Choose the internal word by priority: violation, data, idle, kept codes.
    always_comb begin
        if (viol_i) begin
            word_o = {1'b1, err_val_i};
        end else if (!ctrl_i) begin
            word_o = make_word(1'b0, 1'b0, data_i);
        end else if (idle_o) begin
            word_o = trans_eff_i ? {1'b0, idle_val_i}
                                 : make_word(1'b0, 1'b1, data_i);
        end else if (data_i == ERR_CHAR) begin
            word_o = make_word(1'b1, 1'b1, data_i);
        end else if (is_kept_ctrl(data_i)) begin
            word_o = make_word(1'b0, 1'b1, data_i);
        end else begin
            word_o = {1'b1, err_val_i};
        end
    end
endmodule

// File: rtl/nrm_idle_column.sv
// Module nrm_idle_column
// Output register stage with all-idle column tracking. The first all-idle
// column after a non-idle one is registered as mapped. Later all-idle
// columns keep the registered word, which therefore also serves as the
// stored pattern. Assumes the word is only loaded on valid columns.
module nrm_idle_column
    import nrm_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic [LANES-1:0]        lane_idle_i,
    input  logic [LANES*WORD_W-1:0] mapped_i,
    output logic                    valid_o,
    output logic [LANES*WORD_W-1:0] word_o
);
    logic                    last_nonidle_q;
    logic                    col_idle;
    logic                    repeat_col;
    logic [LANES*WORD_W-1:0] next_word;

    // Detect a full idle column and decide whether it repeats the stored one.
    always_comb begin
        col_idle   = &lane_idle_i;
        repeat_col = col_idle && !last_nonidle_q;
        next_word  = repeat_col ? word_o : mapped_i;
    end

    // Register the column, the valid strobe and the tracking state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_nonidle_q <= 1'b1;
            valid_o        <= 1'b0;
            word_o         <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                word_o         <= next_word;
                last_nonidle_q <= !col_idle;
            end
        end
    end
endmodule

// File: rtl/nrm_column_normalizer.sv
// Module nrm_column_normalizer
// Top level of the four-lane receive character normalizer. It resolves the
// configuration, maps every lane in parallel and registers the column with
// all-idle repetition. Latency is one clock. Assumes the lanes are deskewed
// and decoded upstream.
module nrm_column_normalizer
    import nrm_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*BYTE_W-1:0] in_data,
    input  logic [LANES-1:0]        in_ctrl,
    input  logic [LANES-1:0]        in_viol,
    input  logic                    cfg_translate,
    input  logic                    cfg_xaui,
    input  logic [CFG_W-1:0]        cfg_idle,
    input  logic [CFG_W-1:0]        cfg_error,
    output logic                    out_valid,
    output logic [LANES*WORD_W-1:0] out_word
);
    logic                    trans_eff;
    logic [CFG_W-1:0]        err_val;
    logic [LANES-1:0]        lane_idle;
    logic [LANES*WORD_W-1:0] mapped;

    nrm_cfg_resolve u_cfg (
        .cfg_translate_i (cfg_translate),
        .cfg_xaui_i      (cfg_xaui),
        .cfg_error_i     (cfg_error),
        .trans_eff_o     (trans_eff),
        .err_val_o       (err_val)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        nrm_lane_map u_map (
            .data_i      (in_data[l*BYTE_W +: BYTE_W]),
            .ctrl_i      (in_ctrl[l]),
            .viol_i      (in_viol[l]),
            .trans_eff_i (trans_eff),
            .idle_val_i  (cfg_idle),
            .err_val_i   (err_val),
            .word_o      (mapped[l*WORD_W +: WORD_W]),
            .idle_o      (lane_idle[l])
        );
    end

    nrm_idle_column #(.LANES(LANES)) u_col (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (in_valid),
        .lane_idle_i (lane_idle),
        .mapped_i    (mapped),
        .valid_o     (out_valid),
        .word_o      (out_word)
    );
endmodule

// File: rtl/nrm_column_normalizer_checker.sv
// Module nrm_column_normalizer_checker
// Port-level properties of the normalizer, bound to the top module. It keeps
// its own record of whether the previous valid column was all idle.
module nrm_column_normalizer_checker
    import nrm_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [LANES*BYTE_W-1:0] in_data,
    input logic [LANES-1:0]        in_ctrl,
    input logic [LANES-1:0]        in_viol,
    input logic                    cfg_translate,
    input logic                    cfg_xaui,
    input logic [CFG_W-1:0]        cfg_idle,
    input logic [CFG_W-1:0]        cfg_error,
    input logic                    out_valid,
    input logic [LANES*WORD_W-1:0] out_word
);
    logic [LANES-1:0] chk_idle;
    logic             chk_all_idle;
    logic             chk_prev_idle;

    // Independent idle classification from the inputs.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            chk_idle[l] = in_ctrl[l] && !in_viol[l] &&
                          (in_data[l*BYTE_W +: BYTE_W] == 8'hBC ||
                           in_data[l*BYTE_W +: BYTE_W] == 8'h7C ||
                           in_data[l*BYTE_W +: BYTE_W] == 8'h1C);
        end
        chk_all_idle = &chk_idle;
    end

    // Remember whether the last valid column was all idle.
    always_ff @(posedge clk) begin
        if (!rst_n)        chk_prev_idle <= 1'b0;
        else if (in_valid) chk_prev_idle <= chk_all_idle;
    end

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_word)));
    assert_repeat_column_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_all_idle && chk_prev_idle) |=> $stable(out_word));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        assert_data_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_ctrl[l] && !in_viol[l]) |=>
            out_word[l*WORD_W +: WORD_W] == {2'b00, $past(in_data[l*BYTE_W +: BYTE_W])});
        assert_k30_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ctrl[l] && !in_viol[l] && in_data[l*BYTE_W +: BYTE_W] == 8'hFE) |=>
            out_word[l*WORD_W +: WORD_W] == 10'h3FE);
        assert_error_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_viol[l] && !cfg_xaui) |=>
            out_word[l*WORD_W +: WORD_W] == {1'b1, $past(cfg_error)});
        assert_error_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_viol[l] && cfg_xaui) |=>
            out_word[l*WORD_W +: WORD_W] == 10'h3FE);
        assert_idle_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !chk_all_idle && chk_idle[l] && !cfg_translate && !cfg_xaui) |=>
            out_word[l*WORD_W +: WORD_W] == {2'b01, $past(in_data[l*BYTE_W +: BYTE_W])});
        assert_idle_translated_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !chk_all_idle && chk_idle[l] && (cfg_translate || cfg_xaui)) |=>
            out_word[l*WORD_W +: WORD_W] == {1'b0, $past(cfg_idle)});
    end
endmodule

bind nrm_column_normalizer nrm_column_normalizer_checker #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_ctrl       (in_ctrl),
    .in_viol       (in_viol),
    .cfg_translate (cfg_translate),
    .cfg_xaui      (cfg_xaui),
    .cfg_idle      (cfg_idle),
    .cfg_error     (cfg_error),
    .out_valid     (out_valid),
    .out_word      (out_word)
);

// File: tb/nrm_column_normalizer_test.sv
`timescale 1ns/1ps
module nrm_column_normalizer_test;
    localparam int LANES = 4;
    localparam int VW    = 86;   // {req4, trans, xaui, data32, ctrl4, viol4, exp40}
    localparam int NV    = 16;

    // Table vectors, applied back to back after reset. The idle state carries
    // from one row to the next.
    localparam logic [VW-1:0] TBL [NV] = '{
        {4'd2, 1'b0, 1'b0, 32'h44434241, 4'h0, 4'h0, {10'h044, 10'h043, 10'h042, 10'h041}}, // R2
        {4'd3, 1'b0, 1'b0, 32'h5C3CFDFB, 4'hF, 4'h0, {10'h15C, 10'h13C, 10'h1FD, 10'h1FB}}, // R3
        {4'd3, 1'b0, 1'b0, 32'hF7FCDC9C, 4'hF, 4'h0, {10'h1F7, 10'h1FC, 10'h1DC, 10'h19C}}, // R3
        {4'd4, 1'b0, 1'b0, 32'h00FF80FE, 4'h1, 4'h0, {10'h000, 10'h0FF, 10'h080, 10'h3FE}}, // R4
        {4'd5, 1'b0, 1'b0, 32'h11223344, 4'h0, 4'h2, {10'h011, 10'h022, 10'h2AA, 10'h044}}, // R5
        {4'd5, 1'b0, 1'b0, 32'h00550000, 4'h4, 4'h0, {10'h000, 10'h2AA, 10'h000, 10'h000}}, // R5
        {4'd6, 1'b0, 1'b1, 32'h00000000, 4'h0, 4'h8, {10'h3FE, 10'h000, 10'h000, 10'h000}}, // R6
        {4'd7, 1'b0, 1'b0, 32'hBC7C1CBC, 4'hF, 4'h0, {10'h1BC, 10'h17C, 10'h11C, 10'h1BC}}, // R7
        {4'd9, 1'b0, 1'b0, 32'h1C1C1C1C, 4'hF, 4'h0, {10'h1BC, 10'h17C, 10'h11C, 10'h1BC}}, // R9
        {4'd9, 1'b1, 1'b0, 32'h7C7C7C7C, 4'hF, 4'h0, {10'h1BC, 10'h17C, 10'h11C, 10'h1BC}}, // R9
        {4'd8, 1'b1, 1'b0, 32'hBC41BCBC, 4'hB, 4'h0, {10'h107, 10'h041, 10'h107, 10'h107}}, // R8
        {4'd8, 1'b1, 1'b0, 32'hBC7C1CBC, 4'hF, 4'h0, {10'h107, 10'h107, 10'h107, 10'h107}}, // R8
        {4'd8, 1'b0, 1'b1, 32'hBCBCBC00, 4'hE, 4'h0, {10'h107, 10'h107, 10'h107, 10'h000}}, // R8
        {4'd7, 1'b0, 1'b0, 32'h1CBC7C1C, 4'hF, 4'h0, {10'h11C, 10'h1BC, 10'h17C, 10'h11C}}, // R7
        {4'd5, 1'b0, 1'b0, 32'hBCBCBCBC, 4'hF, 4'h1, {10'h1BC, 10'h1BC, 10'h1BC, 10'h2AA}}, // R5
        {4'd9, 1'b0, 1'b0, 32'hBCBCBCBC, 4'hF, 4'h0, {10'h1BC, 10'h1BC, 10'h1BC, 10'h1BC}}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_data;
    logic [3:0]  in_ctrl;
    logic [3:0]  in_viol;
    logic        cfg_translate;
    logic        cfg_xaui;
    logic [8:0]  cfg_idle;
    logic [8:0]  cfg_error;
    logic        out_valid;
    logic [39:0] out_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    nrm_column_normalizer #(.LANES(LANES)) uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .in_data (in_data), .in_ctrl (in_ctrl), .in_viol (in_viol),
        .cfg_translate (cfg_translate), .cfg_xaui (cfg_xaui),
        .cfg_idle (cfg_idle), .cfg_error (cfg_error),
        .out_valid (out_valid), .out_word (out_word)
    );

    task automatic check(input string req, input logic [40:0] act, input logic [40:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] d, input logic [3:0] c,
                         input logic [3:0] e);
        in_valid = v; in_data = d; in_ctrl = c; in_viol = e;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_translate = 1'b0; cfg_xaui = 1'b0;
        cfg_idle = 9'h107; cfg_error = 9'h0AA;
        drive(1'b1, 32'h12345678, 4'h0, 4'h0);
        repeat (3) @(negedge clk);
        // R10: reset state of the outputs
        check("R10 reset", {out_valid, out_word}, 41'h0);
        rst_n = 1'b1;

        // Table walk: one column per clock.
        for (int i = 0; i < NV; i++) begin
            cfg_translate = TBL[i][81];
            cfg_xaui      = TBL[i][80];
            drive(1'b1, TBL[i][79:48], TBL[i][47:44], TBL[i][43:40]);
            @(negedge clk);
            check($sformatf("R%0d row %0d", TBL[i][85:82], i),
                  {out_valid, out_word}, {1'b1, TBL[i][39:0]});
        end

        // R10: after a second reset the first all-idle column is captured.
        cfg_translate = 1'b0; cfg_xaui = 1'b0;
        rst_n = 1'b0;
        drive(1'b0, 32'h0, 4'h0, 4'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 32'hBCBC7C7C, 4'hF, 4'h0);
        @(negedge clk);
        check("R10 first idle column", {out_valid, out_word},
              {1'b1, 10'h1BC, 10'h1BC, 10'h17C, 10'h17C});

        // R1: a gap column is ignored and the output holds.
        drive(1'b0, 32'h12345678, 4'h0, 4'h3);
        @(negedge clk);
        check("R1 gap", {out_valid, out_word},
              {1'b0, 10'h1BC, 10'h1BC, 10'h17C, 10'h17C});

        // R9: idle run continues across the gap, with new bytes and translation.
        cfg_translate = 1'b1;
        drive(1'b1, 32'h1C1C1C1C, 4'hF, 4'h0);
        @(negedge clk);
        check("R9 repeat after gap", {out_valid, out_word},
              {1'b1, 10'h1BC, 10'h1BC, 10'h17C, 10'h17C});

        // R8: custom idle value on a mixed column.
        cfg_idle = 9'h0F5;
        drive(1'b1, 32'h000000BC, 4'h1, 4'h0);
        @(negedge clk);
        check("R8 custom idle", {out_valid, out_word},
              {1'b1, 10'h000, 10'h000, 10'h000, 10'h0F5});

        // R6: the forced error value ignores cfg_error.
        cfg_xaui = 1'b1; cfg_error = 9'h155;
        drive(1'b1, 32'h00000000, 4'h0, 4'h4);
        @(negedge clk);
        check("R6 forced error", {out_valid, out_word},
              {1'b1, 10'h000, 10'h3FE, 10'h000, 10'h000});

        // R5: the programmed error value is used when the override is off.
        cfg_xaui = 1'b0; cfg_translate = 1'b0;
        drive(1'b1, 32'h00000000, 4'h0, 4'h4);
        @(negedge clk);
        check("R5 programmed error", {out_valid, out_word},
              {1'b1, 10'h000, 10'h355, 10'h000, 10'h000});

        // R1: valid drops one clock after in_valid drops.
        drive(1'b0, 32'h0, 4'h0, 4'h0);
        @(negedge clk);
        check("R1 valid low", {31'h0, out_valid}, 41'h0);

        finish_run();
    end
endmodule